// File: doc/BRIEF.md
# Serial Register-Bank Host Interface

This block lets a host microcontroller reach a small bank of device registers over a four-wire serial link: an active-low select, a serial clock, host-to-device data and device-to-host data. Every exchange opens with one address byte. The address alone sets the direction, the width and whether the register streams, so the link carries no read/write flag. Depending on the address, no byte, one byte, two bytes or an unbounded run of bytes follow. All link pins are brought into the system clock domain through synchronisers. The serial clock must therefore run well below the system clock; one serial half-period of at least eight system clocks is assumed.

On the device side the block drives an 8-bit control word and a 16-bit configuration word, and it samples a 16-bit device word for the host to read. A loop-back stream buffer can be filled and read back in bursts. Event pulses from the device set sticky status bits. An enable mask selects which of those bits raise the interrupt output. Reading the status register clears the bits it reports. An address-only command returns every register to its default value.

Address map (hex): 01 reset command; 10 control write (8 bit); 11 configuration write (16 bit, high byte first); 12 stream write; 20 device word read (16 bit, high byte first); 22 stream read; 6C mask read; 6D mask write; 7E status read (clears). Any other address is unused.

Top module: `reg_serial_slave`

## Requirements
- R1: Bits travel most-significant first. Host data is sampled on the rising serial clock and reply data changes on the falling serial clock. A one-byte write to address 0x10 sets the control output to that byte once the data byte completes.
- R2: A write to address 0x11 takes the first data byte as bits 15:8 and the second as bits 7:0. The configuration output changes only after the second data byte completes.
- R3: A read of address 0x20 returns the device word, high byte first. The word is captured when the address byte completes.
- R4: Each data byte sent to address 0x12 is stored at the next buffer position, starting from position 0. A read of address 0x22 returns the buffer from position 0 onward. Both pointers wrap after BUF_DEPTH bytes.
- R5: Raising select at any point ends the exchange. A partly shifted byte is discarded, nothing uncommitted is written, and the next exchange starts with an address byte.
- R6: Data bytes sent to a read-only or unused address change no register. Bytes beyond a register's width are ignored. An unused address replies with zeros.
- R7: The address-only command 0x01 restores the control output to CTRL_DEF and the configuration output to CFG_DEF. It also clears the mask, the status bits and the stream buffer.
- R8: An event input pulse sets the matching status bit. Status is read at address 0x7E, and that read clears exactly the bits it reported.
- R9: The mask is written at address 0x6D and read back at address 0x6C. The low IRQ_W bits of the data byte are used.
- R10: The interrupt output (active high by default) is asserted while any status bit has its mask bit set. Enabling an already pending cause asserts it, and it deasserts once no enabled bit remains.
- R11: The reply line is 0 while select is high, during the address byte, and for bytes that have no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Link select, active low |
| sclk_i | input | 1 | Link serial clock |
| mosi_i | input | 1 | Host-to-device serial data |
| miso_o | output | 1 | Device-to-host serial data |
| evt_i | input | IRQ_W | Event pulses that set status bits |
| dev_word_i | input | 16 | Device word returned by address 0x20 |
| ctrl_o | output | 8 | Control register value |
| cfg_o | output | 16 | Configuration register value |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that each serial clock phase outlasts the synchroniser delay plus one system clock. They also assume that select moves only while the serial clock is low, so byte completions never overlap a select change. The stimulus holds every serial level for eight system clocks and changes it only on the falling system edge. It moves select only with the serial clock low. Event pulses and device-word changes are kept outside exchanges, so the bench's model of status and capture timing stays unambiguous.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] ADR_RESET  = 8'h01;
   localparam logic [BYTE_W-1:0] ADR_CTRL_W = 8'h10;
   localparam logic [BYTE_W-1:0] ADR_CFG_W  = 8'h11;
   localparam logic [BYTE_W-1:0] ADR_STRM_W = 8'h12;
   localparam logic [BYTE_W-1:0] ADR_DEV_R  = 8'h20;
   localparam logic [BYTE_W-1:0] ADR_STRM_R = 8'h22;
   localparam logic [BYTE_W-1:0] ADR_MASK_R = 8'h6C;
   localparam logic [BYTE_W-1:0] ADR_MASK_W = 8'h6D;
   localparam logic [BYTE_W-1:0] ADR_STAT_R = 8'h7E;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_RESET,
      SEL_CTRL_W,
      SEL_CFG_W,
      SEL_STRM_W,
      SEL_DEV_R,
      SEL_STRM_R,
      SEL_MASK_R,
      SEL_MASK_W,
      SEL_STAT_R
   } reg_sel_e;

endpackage

// File: rtl/ssl_decode.sv
module ssl_decode
   import ssl_pkg::*;
(
   input  logic [BYTE_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   always_comb begin
      case (addr_i)
         ADR_RESET:  sel_o = SEL_RESET;
         ADR_CTRL_W: sel_o = SEL_CTRL_W;
         ADR_CFG_W:  sel_o = SEL_CFG_W;
         ADR_STRM_W: sel_o = SEL_STRM_W;
         ADR_DEV_R:  sel_o = SEL_DEV_R;
         ADR_STRM_R: sel_o = SEL_STRM_R;
         ADR_MASK_R: sel_o = SEL_MASK_R;
         ADR_MASK_W: sel_o = SEL_MASK_W;
         ADR_STAT_R: sel_o = SEL_STAT_R;
         default:    sel_o = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/ssl_shift.sv
module ssl_shift
   import ssl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              cs_act_o,
   output logic              byte_v_o,
   output logic [BYTE_W-1:0] byte_o,
   input  logic              tx_load_i,
   input  logic [BYTE_W-1:0] tx_byte_i
);

   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   logic [SYNC_STAGES-1:0] cs_pipe, sck_pipe, sdi_pipe;
   logic cs_s, sck_s, sdi_s;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_pipe  <= '1;
               sck_pipe <= '0;
               sdi_pipe <= '0;
            end else begin
               cs_pipe  <= cs_n_i;
               sck_pipe <= sclk_i;
               sdi_pipe <= mosi_i;
            end
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_pipe  <= '1;
               sck_pipe <= '0;
               sdi_pipe <= '0;
            end else begin
               cs_pipe  <= {cs_pipe[SYNC_STAGES-2:0], cs_n_i};
               sck_pipe <= {sck_pipe[SYNC_STAGES-2:0], sclk_i};
               sdi_pipe <= {sdi_pipe[SYNC_STAGES-2:0], mosi_i};
            end
         end
      end
   endgenerate

   assign cs_s  = cs_pipe[SYNC_STAGES-1];
   assign sck_s = sck_pipe[SYNC_STAGES-1];
   assign sdi_s = sdi_pipe[SYNC_STAGES-1];

   logic              sck_q;
   logic              rise, fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic              miso_q;
   logic              byte_v_q;
   logic [BYTE_W-1:0] byte_q;

   assign rise = !cs_s &&  sck_s && !sck_q;
   assign fall = !cs_s && !sck_s &&  sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         miso_q   <= 1'b0;
         byte_v_q <= 1'b0;
         byte_q   <= '0;
      end else begin
         sck_q    <= sck_s;
         byte_v_q <= 1'b0;
         if (cs_s) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
            miso_q  <= 1'b0;
         end else begin
            if (rise) begin
               if (bit_cnt == LAST_BIT) begin
                  byte_v_q <= 1'b1;
                  byte_q   <= {rx_sh, sdi_s};
                  bit_cnt  <= '0;
               end else begin
                  rx_sh   <= {rx_sh[BYTE_W-3:0], sdi_s};
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end
            end
            if (tx_load_i) begin
               tx_sh <= tx_byte_i;
            end else if (fall) begin
               miso_q <= tx_sh[BYTE_W-1];
               tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso_o   = miso_q;
   assign cs_act_o = !cs_s;
   assign byte_v_o = byte_v_q;
   assign byte_o   = byte_q;

endmodule

// File: rtl/ssl_regs.sv
module ssl_regs
   import ssl_pkg::*;
#(
   parameter int                IRQ_W     = 8,
   parameter int                BUF_DEPTH = 16,
   parameter logic [BYTE_W-1:0] CTRL_DEF  = '0,
   parameter logic [15:0]       CFG_DEF   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act_i,
   input  logic              byte_v_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [BYTE_W-1:0] cur_addr_o,
   input  reg_sel_e          sel_i,
   output logic              tx_load_o,
   output logic [BYTE_W-1:0] tx_byte_o,
   input  logic [15:0]       dev_word_i,
   output logic [BYTE_W-1:0] ctrl_o,
   output logic [15:0]       cfg_o,
   output logic              soft_rst_o,
   output logic              mask_we_o,
   output logic [IRQ_W-1:0]  mask_wd_o,
   input  logic [IRQ_W-1:0]  mask_i,
   input  logic [IRQ_W-1:0]  stat_i,
   output logic [IRQ_W-1:0]  stat_clr_o
);

   localparam int PTR_W = $clog2(BUF_DEPTH);

   logic [1:0]        byte_idx;
   logic [BYTE_W-1:0] addr_q;
   logic [BYTE_W-1:0] hi_q;
   logic [BYTE_W-1:0] dev_lo_q;
   logic [BYTE_W-1:0] ctrl_q;
   logic [15:0]       cfg_q;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              addr_phase;
   logic              sbuf_we;
   logic [BUF_DEPTH-1:0][BYTE_W-1:0] sbuf_w;
   logic [BYTE_W-1:0] reply;

   assign addr_phase = (byte_idx == 2'd0);
   assign cur_addr_o = addr_phase ? byte_i : addr_q;
   assign sbuf_we    = byte_v_i && cs_act_i && !addr_phase && (sel_i == SEL_STRM_W);

   // Reply for the byte that follows the one just completed
   always_comb begin
      reply      = '0;
      soft_rst_o = 1'b0;
      stat_clr_o = '0;
      mask_we_o  = 1'b0;
      if (byte_v_i && cs_act_i) begin
         if (addr_phase) begin
            case (sel_i)
               SEL_DEV_R:  reply = dev_word_i[15:8];
               SEL_STRM_R: reply = sbuf_w[0];
               SEL_MASK_R: reply[IRQ_W-1:0] = mask_i;
               SEL_STAT_R: begin
                  reply[IRQ_W-1:0] = stat_i;
                  stat_clr_o       = stat_i;
               end
               SEL_RESET:  soft_rst_o = 1'b1;
               default:    reply = '0;
            endcase
         end else begin
            case (sel_i)
               SEL_DEV_R:  if (byte_idx == 2'd1) reply = dev_lo_q;
               SEL_STRM_R: reply = sbuf_w[rd_ptr];
               SEL_MASK_W: if (byte_idx == 2'd1) mask_we_o = 1'b1;
               default:    reply = '0;
            endcase
         end
      end
   end

   assign tx_load_o = byte_v_i && cs_act_i;
   assign tx_byte_o = reply;
   assign mask_wd_o = byte_i[IRQ_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_idx <= '0;
         addr_q   <= '0;
         hi_q     <= '0;
         dev_lo_q <= '0;
         ctrl_q   <= CTRL_DEF;
         cfg_q    <= CFG_DEF;
         wr_ptr   <= '0;
         rd_ptr   <= '0;
      end else begin
         if (!cs_act_i) begin
            byte_idx <= '0;
         end else if (byte_v_i) begin
            if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
            if (addr_phase) begin
               addr_q   <= byte_i;
               dev_lo_q <= dev_word_i[7:0];
               wr_ptr   <= '0;
               rd_ptr   <= PTR_W'(1);
            end else begin
               case (sel_i)
                  SEL_CTRL_W: if (byte_idx == 2'd1) ctrl_q <= byte_i;
                  SEL_CFG_W: begin
                     if (byte_idx == 2'd1)      hi_q  <= byte_i;
                     else if (byte_idx == 2'd2) cfg_q <= {hi_q, byte_i};
                  end
                  SEL_STRM_W: wr_ptr <= wr_ptr + PTR_W'(1);
                  SEL_STRM_R: rd_ptr <= rd_ptr + PTR_W'(1);
                  default: ;
               endcase
            end
         end
         if (soft_rst_o) begin
            ctrl_q <= CTRL_DEF;
            cfg_q  <= CFG_DEF;
         end
      end
   end

   generate
      for (genvar e = 0; e < BUF_DEPTH; e++) begin : g_sbuf
         logic [BYTE_W-1:0] ent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                ent_q <= '0;
            else if (soft_rst_o)                       ent_q <= '0;
            else if (sbuf_we && wr_ptr == PTR_W'(e))   ent_q <= byte_i;
         end
         assign sbuf_w[e] = ent_q;
      end
   endgenerate

   assign ctrl_o = ctrl_q;
   assign cfg_o  = cfg_q;

endmodule

// File: rtl/ssl_irq.sv
module ssl_irq #(
   parameter int IRQ_W          = 8,
   parameter bit IRQ_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst_i,
   input  logic [IRQ_W-1:0] evt_i,
   input  logic [IRQ_W-1:0] clr_i,
   input  logic             mask_we_i,
   input  logic [IRQ_W-1:0] mask_wd_i,
   output logic [IRQ_W-1:0] mask_o,
   output logic [IRQ_W-1:0] stat_o,
   output logic             irq_o
);

   logic [IRQ_W-1:0] mask_q;
   logic [IRQ_W-1:0] stat_q;
   logic             pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q <= '0;
      else if (soft_rst_i) mask_q <= '0;
      else if (mask_we_i)  mask_q <= mask_wd_i;
   end

   generate
      for (genvar b = 0; b < IRQ_W; b++) begin : g_stat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          stat_q[b] <= 1'b0;
            else if (soft_rst_i) stat_q[b] <= 1'b0;
            else                 stat_q[b] <= evt_i[b] | (stat_q[b] & ~clr_i[b]);
         end
      end
   endgenerate

   assign pend = |(stat_q & mask_q);

   generate
      if (IRQ_ACTIVE_LOW) begin : g_irq_low
         assign irq_o = !pend;
      end else begin : g_irq_high
         assign irq_o = pend;
      end
   endgenerate

   assign mask_o = mask_q;
   assign stat_o = stat_q;

endmodule

// File: rtl/reg_serial_slave.sv
module reg_serial_slave
   import ssl_pkg::*;
#(
   parameter int                IRQ_W          = 8,
   parameter int                BUF_DEPTH      = 16,
   parameter int                SYNC_STAGES    = 2,
   parameter bit                IRQ_ACTIVE_LOW = 1'b0,
   parameter logic [BYTE_W-1:0] CTRL_DEF       = 8'h00,
   parameter logic [15:0]       CFG_DEF        = 16'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_i,
   input  logic             sclk_i,
   input  logic             mosi_i,
   output logic             miso_o,
   input  logic [IRQ_W-1:0] evt_i,
   input  logic [15:0]      dev_word_i,
   output logic [7:0]       ctrl_o,
   output logic [15:0]      cfg_o,
   output logic             irq_o
);

   generate
      if (IRQ_W < 1 || IRQ_W > BYTE_W) begin : g_bad_irq_w
         $error("IRQ_W must lie between 1 and 8");
      end
      if (BUF_DEPTH < 2 || (BUF_DEPTH & (BUF_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("BUF_DEPTH must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 1 and 4");
      end
   endgenerate

   logic              cs_act;
   logic              byte_v;
   logic [BYTE_W-1:0] byte_d;
   logic              tx_load;
   logic [BYTE_W-1:0] tx_byte;
   logic [BYTE_W-1:0] cur_addr;
   reg_sel_e          sel;
   logic              soft_rst;
   logic              mask_we;
   logic [IRQ_W-1:0]  mask_wd;
   logic [IRQ_W-1:0]  mask;
   logic [IRQ_W-1:0]  stat;
   logic [IRQ_W-1:0]  stat_clr;

   ssl_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_i    (cs_n_i),
      .sclk_i    (sclk_i),
      .mosi_i    (mosi_i),
      .miso_o    (miso_o),
      .cs_act_o  (cs_act),
      .byte_v_o  (byte_v),
      .byte_o    (byte_d),
      .tx_load_i (tx_load),
      .tx_byte_i (tx_byte)
   );

   ssl_decode u_dec (
      .addr_i (cur_addr),
      .sel_o  (sel)
   );

   ssl_regs #(
      .IRQ_W     (IRQ_W),
      .BUF_DEPTH (BUF_DEPTH),
      .CTRL_DEF  (CTRL_DEF),
      .CFG_DEF   (CFG_DEF)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act_i   (cs_act),
      .byte_v_i   (byte_v),
      .byte_i     (byte_d),
      .cur_addr_o (cur_addr),
      .sel_i      (sel),
      .tx_load_o  (tx_load),
      .tx_byte_o  (tx_byte),
      .dev_word_i (dev_word_i),
      .ctrl_o     (ctrl_o),
      .cfg_o      (cfg_o),
      .soft_rst_o (soft_rst),
      .mask_we_o  (mask_we),
      .mask_wd_o  (mask_wd),
      .mask_i     (mask),
      .stat_i     (stat),
      .stat_clr_o (stat_clr)
   );

   ssl_irq #(
      .IRQ_W          (IRQ_W),
      .IRQ_ACTIVE_LOW (IRQ_ACTIVE_LOW)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst_i (soft_rst),
      .evt_i      (evt_i),
      .clr_i      (stat_clr),
      .mask_we_i  (mask_we),
      .mask_wd_i  (mask_wd),
      .mask_o     (mask),
      .stat_o     (stat),
      .irq_o      (irq_o)
   );

endmodule

// File: rtl/reg_serial_slave_chk.sv
module reg_serial_slave_chk #(
   parameter int          IRQ_W          = 8,
   parameter bit          IRQ_ACTIVE_LOW = 1'b0,
   parameter logic [7:0]  CTRL_DEF       = 8'h00,
   parameter logic [15:0] CFG_DEF        = 16'h0000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_act,
   input logic             byte_v,
   input logic             soft_rst,
   input logic [IRQ_W-1:0] stat,
   input logic [IRQ_W-1:0] mask,
   input logic [IRQ_W-1:0] evt_i,
   input logic             irq_o,
   input logic             miso_o,
   input logic [7:0]       ctrl_o,
   input logic [15:0]      cfg_o
);

   // R1
   ctrl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_o) |-> ($past(byte_v) || $past(soft_rst)));

   // R2
   cfg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_o) |-> ($past(byte_v) || $past(soft_rst)));

   // R5
   idle_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !byte_v);

   // R7
   reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl_o == CTRL_DEF && cfg_o == CFG_DEF && stat == '0 && mask == '0));

   // R8
   evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|evt_i) && !soft_rst) |=> ((stat & $past(evt_i)) == $past(evt_i)));

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & mask) == '0) |-> (irq_o == IRQ_ACTIVE_LOW));

   // R11
   idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !miso_o);

endmodule

bind reg_serial_slave reg_serial_slave_chk #(
   .IRQ_W          (IRQ_W),
   .IRQ_ACTIVE_LOW (IRQ_ACTIVE_LOW),
   .CTRL_DEF       (CTRL_DEF),
   .CFG_DEF        (CFG_DEF)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_act   (cs_act),
   .byte_v   (byte_v),
   .soft_rst (soft_rst),
   .stat     (stat),
   .mask     (mask),
   .evt_i    (evt_i),
   .irq_o    (irq_o),
   .miso_o   (miso_o),
   .ctrl_o   (ctrl_o),
   .cfg_o    (cfg_o)
);

// File: tb/reg_serial_slave_test.sv
`timescale 1ns/1ps
module reg_serial_slave_test;

   localparam int HALF  = 8;
   localparam int IRQ_W = 8;
   localparam int DEPTH = 16;
   localparam logic [7:0]  CTRL_DEF = 8'h00;
   localparam logic [15:0] CFG_DEF  = 16'h0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic mosi = 1'b0;
   logic miso;
   logic [IRQ_W-1:0] evt = '0;
   logic [15:0] dev_word = '0;
   logic [7:0]  ctrl;
   logic [15:0] cfg;
   logic irq;

   always #2.5 clk = ~clk;

   reg_serial_slave #(
      .IRQ_W(IRQ_W), .BUF_DEPTH(DEPTH), .SYNC_STAGES(2),
      .IRQ_ACTIVE_LOW(1'b0), .CTRL_DEF(CTRL_DEF), .CFG_DEF(CFG_DEF)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
      .miso_o(miso), .evt_i(evt), .dev_word_i(dev_word),
      .ctrl_o(ctrl), .cfg_o(cfg), .irq_o(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] txb [0:31];
   logic [7:0] rxb [0:31];

   logic [7:0]  m_ctrl;
   logic [15:0] m_cfg;
   logic [7:0]  m_mask;
   logic [7:0]  m_stat;
   logic [7:0]  m_buf [0:DEPTH-1];

   function automatic logic exp_irq(logic [7:0] mk, logic [7:0] st);
      return |(mk & st);
   endfunction

   function automatic logic [7:0] exp_stream(int k);
      return m_buf[k % DEPTH];
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_byte(input logic [7:0] d, output logic [7:0] q);
      for (int b = 7; b >= 0; b--) begin
         mosi = d[b];
         wait_clk(HALF);
         q[b] = miso;
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic txn(int n);
      logic [7:0] r;
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int k = 0; k < n; k++) begin
         shift_byte(txb[k], r);
         rxb[k] = r;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2 * HALF);
   endtask

   // Sends whole bytes, then a few bits of one more, then drops select
   task automatic txn_abort(int nbytes, int nbits);
      logic [7:0] r;
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int k = 0; k < nbytes; k++) shift_byte(txb[k], r);
      for (int b = 7; b > 7 - nbits; b--) begin
         mosi = txb[nbytes][b];
         wait_clk(HALF);
         sclk = 1'b1;
         wait_clk(HALF);
         sclk = 1'b0;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2 * HALF);
   endtask

   task automatic wr8(logic [7:0] a, logic [7:0] d);
      txb[0] = a; txb[1] = d;
      txn(2);
   endtask

   task automatic wr16(logic [7:0] a, logic [15:0] d);
      txb[0] = a; txb[1] = d[15:8]; txb[2] = d[7:0];
      txn(3);
   endtask

   task automatic rd8(logic [7:0] a);
      txb[0] = a; txb[1] = 8'h00;
      txn(2);
   endtask

   task automatic pulse_evt(logic [7:0] v);
      @(negedge clk);
      evt = v;
      @(negedge clk);
      evt = '0;
      wait_clk(2);
      m_stat = m_stat | v;
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      wait_clk(150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      int len, rlen, op;
      logic [7:0] v8;
      logic [15:0] v16;
      void'($urandom(32'h00C0FFEE));
      m_ctrl = CTRL_DEF; m_cfg = CFG_DEF; m_mask = '0; m_stat = '0;
      for (int i = 0; i < DEPTH; i++) m_buf[i] = '0;

      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);

      // Reset state
      check("R7 reset ctrl", 32'(ctrl), 32'(CTRL_DEF));
      check("R7 reset cfg", 32'(cfg), 32'(CFG_DEF));
      check("R10 reset irq", 32'(irq), 32'd0);
      check("R11 idle miso", 32'(miso), 32'd0);

      // R1: one-byte write, MSB first
      wr8(8'h10, 8'hA5); m_ctrl = 8'hA5;
      check("R1 ctrl write", 32'(ctrl), 32'(m_ctrl));
      wr8(8'h10, 8'h01); m_ctrl = 8'h01;
      check("R1 ctrl bit order", 32'(ctrl), 32'(m_ctrl));

      // R2: first byte only must not commit
      txb[0] = 8'h11; txb[1] = 8'h12;
      txn(2);
      check("R2 no commit after one byte", 32'(cfg), 32'(m_cfg));
      wr16(8'h11, 16'hBEEF); m_cfg = 16'hBEEF;
      check("R2 cfg write high first", 32'(cfg), 32'(m_cfg));

      // R6: bytes past the width are ignored
      txb[0] = 8'h11; txb[1] = 8'h01; txb[2] = 8'h02; txb[3] = 8'h03;
      txn(4); m_cfg = 16'h0102;
      check("R6 cfg extra bytes ignored", 32'(cfg), 32'(m_cfg));
      txb[0] = 8'h10; txb[1] = 8'h11; txb[2] = 8'h22;
      txn(3); m_ctrl = 8'h11;
      check("R6 ctrl extra bytes ignored", 32'(ctrl), 32'(m_ctrl));

      // R3: 16-bit read, high byte first; R11 address byte replies zero
      dev_word = 16'h1234;
      txb[0] = 8'h20; txb[1] = 8'hFF; txb[2] = 8'hFF;
      txn(3);
      check("R3 dev read high", 32'(rxb[1]), 32'h12);
      check("R3 dev read low", 32'(rxb[2]), 32'h34);
      check("R11 address byte reply", 32'(rxb[0]), 32'h00);
      check("R6 data to read-only addr", 32'(ctrl), 32'(m_ctrl));

      // R5: abort inside address byte, then inside data byte
      txb[0] = 8'h10; txb[1] = 8'hFF;
      txn_abort(0, 4);
      check("R5 abort in address", 32'(ctrl), 32'(m_ctrl));
      txn_abort(1, 5);
      check("R5 abort in data", 32'(ctrl), 32'(m_ctrl));
      txb[0] = 8'h11; txb[1] = 8'h77; txb[2] = 8'h88;
      txn_abort(2, 3);
      check("R5 abort in second cfg byte", 32'(cfg), 32'(m_cfg));
      wr8(8'h10, 8'h3C); m_ctrl = 8'h3C;
      check("R5 next exchange framed", 32'(ctrl), 32'(m_ctrl));

      // R6: unused address
      txb[0] = 8'h55; txb[1] = 8'hAA; txb[2] = 8'h5A;
      txn(3);
      check("R6 unused reply", 32'({rxb[1], rxb[2]}), 32'h0000);
      check("R6 unused ctrl", 32'(ctrl), 32'(m_ctrl));
      check("R6 unused cfg", 32'(cfg), 32'(m_cfg));

      // R4: streaming with wrap
      for (int r = 0; r < 4; r++) begin
         len = $urandom_range(1, DEPTH + 4);
         txb[0] = 8'h12;
         for (int k = 0; k < len; k++) begin
            txb[k+1] = 8'($urandom);
            m_buf[k % DEPTH] = txb[k+1];
         end
         txn(len + 1);
         rlen = $urandom_range(1, DEPTH + 4);
         txb[0] = 8'h22;
         for (int k = 0; k < rlen; k++) txb[k+1] = 8'h00;
         txn(rlen + 1);
         for (int k = 0; k < rlen; k++)
            check("R4 stream readback", 32'(rxb[k+1]), 32'(exp_stream(k)));
      end

      // R8/R9/R10: interrupts
      pulse_evt(8'h05);
      check("R10 masked pending", 32'(irq), 32'(exp_irq(m_mask, m_stat)));
      rd8(8'h7E);
      check("R8 status read", 32'(rxb[1]), 32'(m_stat));
      m_stat = '0;
      rd8(8'h7E);
      check("R8 status cleared", 32'(rxb[1]), 32'h00);
      pulse_evt(8'h09);
      wr8(8'h6D, 8'h01); m_mask = 8'h01;
      check("R10 enable pending", 32'(irq), 32'(exp_irq(m_mask, m_stat)));
      rd8(8'h6C);
      check("R9 mask readback", 32'(rxb[1]), 32'(m_mask));
      rd8(8'h7E);
      check("R8 status read two", 32'(rxb[1]), 32'(m_stat));
      m_stat = '0;
      check("R10 deassert after clear", 32'(irq), 32'(exp_irq(m_mask, m_stat)));

      // Random mix
      for (int i = 0; i < 16; i++) begin
         op = $urandom_range(0, 3);
         case (op)
            0: begin v8 = 8'($urandom); wr8(8'h10, v8); m_ctrl = v8; end
            1: begin v16 = 16'($urandom); wr16(8'h11, v16); m_cfg = v16; end
            2: begin
               pulse_evt(8'($urandom));
               v8 = 8'($urandom); wr8(8'h6D, v8); m_mask = v8;
               check("R10 random irq", 32'(irq), 32'(exp_irq(m_mask, m_stat)));
            end
            default: begin
               rd8(8'h7E);
               check("R8 random status", 32'(rxb[1]), 32'(m_stat));
               m_stat = '0;
               check("R10 random irq after read", 32'(irq), 32'(exp_irq(m_mask, m_stat)));
            end
         endcase
         check("R1 random ctrl", 32'(ctrl), 32'(m_ctrl));
         check("R2 random cfg", 32'(cfg), 32'(m_cfg));
      end

      // R7: reset command
      pulse_evt(8'h80);
      wr8(8'h6D, 8'hFF);
      txb[0] = 8'h01;
      txn(1);
      check("R7 cmd ctrl", 32'(ctrl), 32'(CTRL_DEF));
      check("R7 cmd cfg", 32'(cfg), 32'(CFG_DEF));
      check("R7 cmd irq", 32'(irq), 32'd0);
      rd8(8'h6C);
      check("R7 cmd mask", 32'(rxb[1]), 32'h00);
      rd8(8'h7E);
      check("R7 cmd status", 32'(rxb[1]), 32'h00);
      rd8(8'h22);
      check("R7 cmd stream", 32'(rxb[1]), 32'h00);
      check("R11 idle after", 32'(miso), 32'd0);

      done = 1'b1;
      finish_run();
   end

endmodule